// File: doc/BRIEF.md
# External Bus Wait-State Controller

This block runs single transfers between a processor core and an external memory or I/O bus. The core presents an address, write data, a direction and a space select, and holds its request until the controller accepts it from the idle state. For each transfer the controller applies a programmable number of software wait states (0 to 7). When two or more are programmed, it also waits for an external ready line before it finishes. At the end it returns the read data together with a one-cycle done pulse.

The controller drives the address and data buses, an active-low read/write line (low means write), an active-low I/O strobe and an active-low microstate-complete line. That line is low while the software wait states are still running. Wiring it back to the ready input therefore adds exactly one external wait state. An external master can take the bus with a hold request, and that request is granted only between transfers. A global active-low off input releases every bus output. Each tri-state is modelled as an output enable per signal group.

Top module: `ext_bus_wait_ctrl`

## Requirements
- R1: While reset is held and right after it, holda_n is high, core_done is low, and bus_rw_n, bus_iostrb_n and msc_n are high.
- R2: With a wait count of 0 or 1, a transfer lasts wait+1 bus cycles and rdy_in is not consulted, even when it is low.
- R3: With a wait count of 2 or more and rdy_in held high, a transfer lasts wait+1 bus cycles.
- R4: With a wait count of 2 or more, completion is decided at the end of the last software wait state and then once per extra cycle. The decision uses rdy_in as registered at the previous clock edge, and each low value found adds one cycle.
- R5: msc_n is low from the first software wait state up to, but not including, the last one (wait-1 cycles). With a wait count below 2 it never goes low.
- R6: When msc_n is fed back to rdy_in, a transfer with a wait count of 2 or more lasts exactly wait+2 bus cycles.
- R7: bus_rw_n is high when idle and low only during the bus cycles of a write transfer.
- R8: bus_iostrb_n is low only during the bus cycles of an I/O-space transfer (req_io=1), and high otherwise.
- R9: core_done is a one-cycle pulse one clock after the final bus cycle. core_rdata then holds bus_rdata_in as sampled in that final cycle.
- R10: A high hold_req is granted only from idle, and it wins over a pending request. While granted, holda_n is low and the address, data and control enables are low. A request made during hold waits until hold is released.
- R11: When off_n is low, every output enable (address, data, control, msc_oe, holda_oe) is low.
- R12: The wait count is captured when a transfer is accepted. Changing cfg_wait during the transfer does not change its length.
- R13: bus_data_oe is high only during the bus cycles of a write transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core request, held until accepted |
| req_addr | input | AW | Transfer address |
| req_wdata | input | DW | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory space |
| cfg_wait | input | WSW | Software wait-state count |
| rdy_in | input | 1 | External ready, high = ready |
| hold_req | input | 1 | External bus hold request, active high |
| off_n | input | 1 | Global output disable, active low |
| bus_rdata_in | input | DW | Data read from the external bus |
| bus_addr | output | AW | Address bus |
| bus_addr_oe | output | 1 | Address bus enable |
| bus_wdata | output | DW | Data bus output value |
| bus_data_oe | output | 1 | Data bus enable |
| bus_rw_n | output | 1 | Read/write line, low = write |
| bus_iostrb_n | output | 1 | I/O strobe, active low |
| bus_ctl_oe | output | 1 | Enable for read/write line and I/O strobe |
| msc_n | output | 1 | Microstate complete, low while software waits remain |
| msc_oe | output | 1 | Enable for msc_n |
| holda_n | output | 1 | Hold acknowledge, active low |
| holda_oe | output | 1 | Enable for holda_n |
| core_done | output | 1 | One-cycle transfer done pulse |
| core_rdata | output | DW | Captured read data |

## Verification
Transfers are run with wait counts from 0 to 7 under three ready patterns: ready held high, ready held low, and msc_n looped back to ready. Holding ready low with counts below 2 shows that ready is not consulted there. Holding it high with counts of 2 and more separates the no-extra-cycle case from the loop-back case, which must add exactly one cycle. Raising ready late in a long transfer pins down the one-cycle registered sampling. Reads, writes, memory space and I/O space are mixed so that the strobe, the direction line and the data enable are each tied to the correct transfer type. Hold is requested both from idle and in the middle of a transfer, which shows that the grant waits for the transfer boundary.

// File: rtl/ebw_pkg.sv
// Package: shared state encoding for the external bus wait-state controller.
// Assumes: imported by every module of the controller and its checker.
package ebw_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,   // no transfer, bus owned
        ST_ACC,    // first bus cycle of a transfer
        ST_WS,     // software wait states
        ST_XW,     // extra cycles waiting on ready
        ST_HOLD    // bus handed to external master
    } ebw_state_t;
endpackage

// File: rtl/ebw_sequencer.sv
// Module: transfer sequencer. Accepts a core request from idle, runs the
// access cycle and the software wait states, then samples registered ready.
// Assumes: req_valid is held until the transfer is accepted and dropped
// before the done pulse; the hold request is honoured only from idle.
module ebw_sequencer
    import ebw_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int WSW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    input  logic             req_write,
    input  logic             req_io,
    input  logic [WSW-1:0]   cfg_wait,
    input  logic             rdy_in,
    input  logic             hold_req,
    output ebw_state_t       st,
    output logic [WSW-1:0]   ws_left,
    output logic [WSW-1:0]   ws_cfg,
    output logic [AW-1:0]    cur_addr,
    output logic [DW-1:0]    cur_wdata,
    output logic             cur_write,
    output logic             cur_io,
    output logic             finish
);
    localparam logic [WSW-1:0] READY_MIN = WSW'(2);
    localparam logic [WSW-1:0] ONE       = WSW'(1);

    ebw_state_t     st_nx;
    logic [WSW-1:0] left_nx;
    logic           rdy_q;
    logic           accept;

    assign accept = (st == ST_IDLE) && !hold_req && req_valid;

    // Register the ready input; decisions use the value of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) rdy_q <= 1'b0;
        else        rdy_q <= rdy_in;
    end

    // Next state, remaining wait count and end-of-transfer flag.
    always_comb begin
        st_nx   = st;
        left_nx = ws_left;
        finish  = 1'b0;
        case (st)
            ST_IDLE: begin
                if (hold_req)       st_nx = ST_HOLD;
                else if (req_valid) st_nx = ST_ACC;
            end
            ST_ACC: begin
                if (ws_cfg == '0) begin
                    finish = 1'b1;
                    st_nx  = ST_IDLE;
                end else begin
                    st_nx   = ST_WS;
                    left_nx = ws_cfg;
                end
            end
            ST_WS: begin
                if (ws_left == ONE) begin
                    if (ws_cfg < READY_MIN || rdy_q) begin
                        finish = 1'b1;
                        st_nx  = ST_IDLE;
                    end else begin
                        st_nx = ST_XW;
                    end
                end else begin
                    left_nx = ws_left - ONE;
                end
            end
            ST_XW: begin
                if (rdy_q) begin
                    finish = 1'b1;
                    st_nx  = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (!hold_req) st_nx = ST_IDLE;
            end
            default: st_nx = ST_IDLE;
        endcase
    end

    // State and wait counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            ws_left <= '0;
        end else begin
            st      <= st_nx;
            ws_left <= left_nx;
        end
    end

    // Capture the request fields and the wait count at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_cfg    <= '0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            cur_write <= 1'b0;
            cur_io    <= 1'b0;
        end else if (accept) begin
            ws_cfg    <= cfg_wait;
            cur_addr  <= req_addr;
            cur_wdata <= req_wdata;
            cur_write <= req_write;
            cur_io    <= req_io;
        end
    end
endmodule

// File: rtl/ebw_pin_drive.sv
// Module: bus pin driver. Derives line levels and output enables from the
// sequencer state.
// Assumes: purely combinational; off_n overrides every enable.
module ebw_pin_drive
    import ebw_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int WSW = 3
) (
    input  ebw_state_t     st,
    input  logic [WSW-1:0] ws_left,
    input  logic [AW-1:0]  cur_addr,
    input  logic [DW-1:0]  cur_wdata,
    input  logic           cur_write,
    input  logic           cur_io,
    input  logic           off_n,
    output logic [AW-1:0]  bus_addr,
    output logic           bus_addr_oe,
    output logic [DW-1:0]  bus_wdata,
    output logic           bus_data_oe,
    output logic           bus_rw_n,
    output logic           bus_iostrb_n,
    output logic           bus_ctl_oe,
    output logic           msc_n,
    output logic           msc_oe,
    output logic           holda_n,
    output logic           holda_oe
);
    localparam logic [WSW-1:0] TWO = WSW'(2);

    logic active;
    logic granted;

    // Classify the state into transfer and hold.
    always_comb begin
        active  = (st == ST_ACC) || (st == ST_WS) || (st == ST_XW);
        granted = (st == ST_HOLD);
    end

    // Line levels and per-group enables.
    always_comb begin
        bus_addr     = cur_addr;
        bus_wdata    = cur_wdata;
        bus_rw_n     = !(active && cur_write);
        bus_iostrb_n = !(active && cur_io);
        msc_n        = !((st == ST_WS) && (ws_left >= TWO));
        holda_n      = !granted;
        bus_addr_oe  = off_n && !granted;
        bus_ctl_oe   = off_n && !granted;
        bus_data_oe  = off_n && active && cur_write;
        msc_oe       = off_n;
        holda_oe     = off_n;
    end
endmodule

// File: rtl/ebw_read_capture.sv
// Module: read capture. Latches bus read data and pulses done on the
// edge that closes the final bus cycle.
// Assumes: finish is high for exactly one cycle per transfer.
module ebw_read_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          finish,
    input  logic [DW-1:0] bus_rdata_in,
    output logic          core_done,
    output logic [DW-1:0] core_rdata
);
    // Capture data and raise the done pulse for one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            core_done  <= 1'b0;
            core_rdata <= '0;
        end else begin
            core_done <= finish;
            if (finish) core_rdata <= bus_rdata_in;
        end
    end
endmodule

// File: rtl/ext_bus_wait_ctrl.sv
// Module: external bus wait-state controller top. Connects the sequencer,
// the pin driver and the read capture.
// Assumes: one outstanding transfer at a time; synchronous active-low reset.
module ext_bus_wait_ctrl
    import ebw_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int WSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           req_valid,
    input  logic [AW-1:0]  req_addr,
    input  logic [DW-1:0]  req_wdata,
    input  logic           req_write,
    input  logic           req_io,
    input  logic [WSW-1:0] cfg_wait,
    input  logic           rdy_in,
    input  logic           hold_req,
    input  logic           off_n,
    input  logic [DW-1:0]  bus_rdata_in,
    output logic [AW-1:0]  bus_addr,
    output logic           bus_addr_oe,
    output logic [DW-1:0]  bus_wdata,
    output logic           bus_data_oe,
    output logic           bus_rw_n,
    output logic           bus_iostrb_n,
    output logic           bus_ctl_oe,
    output logic           msc_n,
    output logic           msc_oe,
    output logic           holda_n,
    output logic           holda_oe,
    output logic           core_done,
    output logic [DW-1:0]  core_rdata
);
    ebw_state_t     st;
    logic [WSW-1:0] ws_left;
    logic [WSW-1:0] ws_cfg;
    logic [AW-1:0]  cur_addr;
    logic [DW-1:0]  cur_wdata;
    logic           cur_write;
    logic           cur_io;
    logic           finish;

    ebw_sequencer #(.AW(AW), .DW(DW), .WSW(WSW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_write (req_write),
        .req_io    (req_io),
        .cfg_wait  (cfg_wait),
        .rdy_in    (rdy_in),
        .hold_req  (hold_req),
        .st        (st),
        .ws_left   (ws_left),
        .ws_cfg    (ws_cfg),
        .cur_addr  (cur_addr),
        .cur_wdata (cur_wdata),
        .cur_write (cur_write),
        .cur_io    (cur_io),
        .finish    (finish)
    );

    ebw_pin_drive #(.AW(AW), .DW(DW), .WSW(WSW)) u_pins (
        .st           (st),
        .ws_left      (ws_left),
        .cur_addr     (cur_addr),
        .cur_wdata    (cur_wdata),
        .cur_write    (cur_write),
        .cur_io       (cur_io),
        .off_n        (off_n),
        .bus_addr     (bus_addr),
        .bus_addr_oe  (bus_addr_oe),
        .bus_wdata    (bus_wdata),
        .bus_data_oe  (bus_data_oe),
        .bus_rw_n     (bus_rw_n),
        .bus_iostrb_n (bus_iostrb_n),
        .bus_ctl_oe   (bus_ctl_oe),
        .msc_n        (msc_n),
        .msc_oe       (msc_oe),
        .holda_n      (holda_n),
        .holda_oe     (holda_oe)
    );

    ebw_read_capture #(.DW(DW)) u_cap (
        .clk          (clk),
        .rst_n        (rst_n),
        .finish       (finish),
        .bus_rdata_in (bus_rdata_in),
        .core_done    (core_done),
        .core_rdata   (core_rdata)
    );
endmodule

// File: rtl/ebw_checker.sv
// Module: property checker for the external bus wait-state controller.
// Assumes: bound into ext_bus_wait_ctrl; observes ports and sequencer state.
module ebw_checker
    import ebw_pkg::*;
#(
    parameter int WSW = 3
) (
    input logic           clk,
    input logic           rst_n,
    input ebw_state_t     st,
    input logic [WSW-1:0] ws_cfg,
    input logic           off_n,
    input logic           msc_n,
    input logic           msc_oe,
    input logic           bus_rw_n,
    input logic           bus_iostrb_n,
    input logic           bus_data_oe,
    input logic           bus_addr_oe,
    input logic           bus_ctl_oe,
    input logic           holda_n,
    input logic           holda_oe,
    input logic           core_done
);
    assert_extra_cycle_needs_two_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_XW) |-> (ws_cfg >= WSW'(2)));

    assert_msc_inside_waits_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !msc_n |-> ((st == ST_WS) && (ws_cfg >= WSW'(2))));

    assert_write_only_in_transfer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rw_n |-> (st != ST_IDLE && st != ST_HOLD));

    assert_strobe_only_in_transfer_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_iostrb_n |-> (st != ST_IDLE && st != ST_HOLD));

    assert_done_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        core_done |=> !core_done);

    assert_hold_at_boundary_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(holda_n) |-> ($past(st) == ST_IDLE));

    assert_hold_floats_bus_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !holda_n |-> (!bus_addr_oe && !bus_data_oe && !bus_ctl_oe));

    assert_off_disables_all_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !off_n |-> !(bus_addr_oe || bus_data_oe || bus_ctl_oe || msc_oe || holda_oe));

    assert_count_stable_in_waits_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WS) |-> $stable(ws_cfg));

    assert_data_only_on_write_R13: assert property (@(posedge clk) disable iff (!rst_n)
        bus_data_oe |-> !bus_rw_n);
endmodule

bind ext_bus_wait_ctrl ebw_checker #(.WSW(WSW)) u_ebw_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .st           (st),
    .ws_cfg       (ws_cfg),
    .off_n        (off_n),
    .msc_n        (msc_n),
    .msc_oe       (msc_oe),
    .bus_rw_n     (bus_rw_n),
    .bus_iostrb_n (bus_iostrb_n),
    .bus_data_oe  (bus_data_oe),
    .bus_addr_oe  (bus_addr_oe),
    .bus_ctl_oe   (bus_ctl_oe),
    .holda_n      (holda_n),
    .holda_oe     (holda_oe),
    .core_done    (core_done)
);

// File: tb/ext_bus_wait_ctrl_bench.sv
`timescale 1ns/1ps
module ext_bus_wait_ctrl_bench;
    localparam int AW  = 16;
    localparam int DW  = 16;
    localparam int WSW = 3;
    localparam int NV  = 8;
    // Vector fields: [11] write, [10] io, [9:7] wait count,
    // [6:5] ready mode (0 high, 1 low, 2 msc loop-back), [4:0] bus cycles.
    localparam logic [11:0] VEC [NV] = '{
        {1'b0, 1'b0, 3'd0, 2'd0, 5'd1},
        {1'b1, 1'b0, 3'd1, 2'd1, 5'd2},
        {1'b0, 1'b1, 3'd2, 2'd0, 5'd3},
        {1'b1, 1'b1, 3'd3, 2'd2, 5'd5},
        {1'b0, 1'b0, 3'd7, 2'd2, 5'd9},
        {1'b0, 1'b0, 3'd5, 2'd0, 5'd6},
        {1'b1, 1'b0, 3'd2, 2'd2, 5'd4},
        {1'b0, 1'b1, 3'd1, 2'd2, 5'd2}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic [AW-1:0]  req_addr = '0;
    logic [DW-1:0]  req_wdata = '0;
    logic           req_write = 1'b0;
    logic           req_io = 1'b0;
    logic [WSW-1:0] cfg_wait = '0;
    logic           rdy_drv = 1'b1;
    int             rdy_mode = 0;
    logic           rdy_in;
    logic           hold_req = 1'b0;
    logic           off_n = 1'b1;
    logic [DW-1:0]  bus_rdata_in = '0;
    logic [AW-1:0]  bus_addr;
    logic           bus_addr_oe;
    logic [DW-1:0]  bus_wdata;
    logic           bus_data_oe;
    logic           bus_rw_n;
    logic           bus_iostrb_n;
    logic           bus_ctl_oe;
    logic           msc_n;
    logic           msc_oe;
    logic           holda_n;
    logic           holda_oe;
    logic           core_done;
    logic [DW-1:0]  core_rdata;

    int errors = 0;
    int checks = 0;

    assign rdy_in = (rdy_mode == 2) ? msc_n : rdy_drv;

    always #2.5 clk = ~clk;

    ext_bus_wait_ctrl #(.AW(AW), .DW(DW), .WSW(WSW)) u_ext_bus_wait_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_wdata(req_wdata), .req_write(req_write), .req_io(req_io),
        .cfg_wait(cfg_wait), .rdy_in(rdy_in), .hold_req(hold_req), .off_n(off_n),
        .bus_rdata_in(bus_rdata_in), .bus_addr(bus_addr), .bus_addr_oe(bus_addr_oe),
        .bus_wdata(bus_wdata), .bus_data_oe(bus_data_oe), .bus_rw_n(bus_rw_n),
        .bus_iostrb_n(bus_iostrb_n), .bus_ctl_oe(bus_ctl_oe), .msc_n(msc_n),
        .msc_oe(msc_oe), .holda_n(holda_n), .holda_oe(holda_oe),
        .core_done(core_done), .core_rdata(core_rdata)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One transfer; seen is the negedge index (from acceptance) where done is observed.
    task automatic run_txn(input logic w, input logic io, input logic [2:0] ws,
                           input int mode, input logic [DW-1:0] rd,
                           input int raise_at, input int cfg_change_at,
                           output int seen, output int msc_lo, output bit rw_bad,
                           output bit io_bad, output bit d_bad, output logic [DW-1:0] got);
        @(negedge clk);
        req_write = w; req_io = io; cfg_wait = ws; rdy_mode = mode;
        rdy_drv = (mode == 1) ? 1'b0 : 1'b1;
        bus_rdata_in = rd; req_addr = {8'h5A, rd[7:0]}; req_wdata = ~rd;
        req_valid = 1'b1;
        seen = 0; msc_lo = 0; rw_bad = 0; io_bad = 0; d_bad = 0; got = '0;
        for (int k = 1; k <= 60; k++) begin
            @(posedge clk); @(negedge clk);
            if (k == 1) req_valid = 1'b0;
            if (core_done) begin seen = k; got = core_rdata; break; end
            if (!msc_n) msc_lo++;
            if (bus_rw_n !== !w) rw_bad = 1;
            if (bus_iostrb_n !== !io) io_bad = 1;
            if (bus_data_oe !== w) d_bad = 1;
            if (k == raise_at) rdy_drv = 1'b1;
            if (k == cfg_change_at) cfg_wait = 3'd7;
        end
        rdy_mode = 0; rdy_drv = 1'b1;
    endtask

    initial begin
        #(5.0 * 100000);
        errors++; checks++;
        $display("FAIL watchdog expired before completion (all requirements)");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int seen, mlo, exp_m;
        bit rwb, iob, db;
        logic [DW-1:0] got;
        string tag;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(holda_n === 1'b1, "R1 holda_n in reset", holda_n, 1);
        check(core_done === 1'b0 && bus_rw_n === 1'b1 && bus_iostrb_n === 1'b1 && msc_n === 1'b1,
              "R1 idle levels in reset", {core_done, bus_rw_n, bus_iostrb_n, msc_n}, 4'b0111);
        rst_n = 1'b1;
        @(negedge clk);
        check(holda_n === 1'b1 && bus_rw_n === 1'b1, "R1 after reset", {holda_n, bus_rw_n}, 2'b11);

        // Table-driven transfers: R2, R3, R5, R6, R7, R8, R9, R13
        for (int i = 0; i < NV; i++) begin
            logic [11:0] v;
            v = VEC[i];
            run_txn(v[11], v[10], v[9:7], int'(v[6:5]), DW'(16'hA500 + i), 0, 0,
                    seen, mlo, rwb, iob, db, got);
            tag = (v[9:7] < 3'd2) ? "R2" : ((v[6:5] == 2'd2) ? "R6" : "R3");
            check(seen == int'(v[4:0]) + 1, $sformatf("%s latency vec %0d", tag, i), seen, int'(v[4:0]) + 1);
            exp_m = (v[9:7] >= 3'd2) ? int'(v[9:7]) - 1 : 0;
            check(mlo == exp_m, $sformatf("R5 msc low cycles vec %0d", i), mlo, exp_m);
            check(!rwb, $sformatf("R7 rw line vec %0d", i), rwb, 0);
            check(!iob, $sformatf("R8 io strobe vec %0d", i), iob, 0);
            check(!db, $sformatf("R13 data enable vec %0d", i), db, 0);
            if (!v[11]) check(got == DW'(16'hA500 + i), $sformatf("R9 read data vec %0d", i), got, 16'hA500 + i);
            @(negedge clk);
            check(core_done === 1'b0, $sformatf("R9 done one cycle vec %0d", i), core_done, 0);
            check(bus_rw_n === 1'b1, $sformatf("R7 idle high vec %0d", i), bus_rw_n, 1);
        end

        // R4: ready held low, raised at sample 6 with wait 3 -> 7 bus cycles
        run_txn(1'b0, 1'b0, 3'd3, 1, 16'h1234, 6, 0, seen, mlo, rwb, iob, db, got);
        check(seen == 8, "R4 late ready", seen, 8);
        check(got == 16'h1234, "R4 data after late ready", got, 16'h1234);

        // R12: wait count changed mid-transfer has no effect
        run_txn(1'b0, 1'b0, 3'd2, 0, 16'h0F0F, 0, 1, seen, mlo, rwb, iob, db, got);
        check(seen == 4, "R12 captured count", seen, 4);

        // R11: off_n disables every enable
        @(negedge clk);
        off_n = 1'b0;
        #1;
        check({bus_addr_oe, bus_data_oe, bus_ctl_oe, msc_oe, holda_oe} == 5'b0,
              "R11 off disables", {bus_addr_oe, bus_data_oe, bus_ctl_oe, msc_oe, holda_oe}, 0);
        off_n = 1'b1;
        #1;
        check(bus_addr_oe && bus_ctl_oe && msc_oe && holda_oe, "R11 on again",
              {bus_addr_oe, bus_ctl_oe, msc_oe, holda_oe}, 4'b1111);

        // R10: hold from idle wins over a pending request
        @(negedge clk);
        hold_req = 1'b1; req_valid = 1'b1; req_write = 1'b0; req_io = 1'b1; cfg_wait = 3'd0;
        bus_rdata_in = 16'hBEEF;
        @(posedge clk); @(negedge clk);
        check(holda_n === 1'b0 && !bus_addr_oe && !bus_ctl_oe && !bus_data_oe, "R10 hold granted",
              {holda_n, bus_addr_oe, bus_ctl_oe, bus_data_oe}, 0);
        begin
            bit early = 0;
            for (int k = 0; k < 3; k++) begin
                @(posedge clk); @(negedge clk);
                if (core_done || holda_n) early = 1;
            end
            check(!early, "R10 request waits during hold", early, 0);
        end
        hold_req = 1'b0;
        seen = 0;
        for (int k = 1; k <= 10; k++) begin
            @(posedge clk); @(negedge clk);
            if (!bus_iostrb_n) req_valid = 1'b0;
            if (core_done) begin seen = k; break; end
        end
        req_valid = 1'b0;
        check(seen == 3, "R10 request served after release", seen, 3);
        check(core_rdata == 16'hBEEF, "R10 data after hold", core_rdata, 16'hBEEF);

        // R10: hold raised mid-transfer is granted only after done
        @(negedge clk);
        req_write = 1'b0; req_io = 1'b0; cfg_wait = 3'd5; req_valid = 1'b1;
        begin
            bit bad = 0;
            seen = 0;
            for (int k = 1; k <= 20; k++) begin
                @(posedge clk); @(negedge clk);
                if (k == 1) req_valid = 1'b0;
                if (k == 2) hold_req = 1'b1;
                if (holda_n !== 1'b1) bad = 1;
                if (core_done) begin seen = k; break; end
            end
            check(!bad, "R10 no grant mid-transfer", bad, 0);
            check(seen == 7, "R10 transfer length with hold pending", seen, 7);
        end
        @(negedge clk);
        check(holda_n === 1'b0, "R10 grant at boundary", holda_n, 0);
        hold_req = 1'b0;
        @(negedge clk); @(negedge clk);
        check(holda_n === 1'b1, "R10 release", holda_n, 1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule